// File: doc/BRIEF.md
# Monitor channel handshake controller

This block runs both ends of a byte-wide monitor channel carried on a time-division-multiplexed serial bus. Each bus frame holds one monitor byte and two handshake bits, both active low. The transmit end drives MX and the receive end drives MR. A single-cycle frame strobe marks each frame boundary. All bus-side outputs are sampled and updated only on that strobe. Bit serialization and host bus decoding are handled outside the block.

On the transmit side, the host writes a byte. The block shows it on the bus by pulling MX active and waits for the far end to pull MR active. It then releases MX and raises a transmit-request flag so the host can write the next byte. With no byte pending after an acknowledge, an end-of-message request ends the message by keeping MX inactive for a second frame.

On the receive side, the block accepts a byte when MX goes from inactive to active. It stores the byte, flags it as available, pulses an interrupt and acknowledges with MR. A host abort request makes the receiver hold MR inactive for two frames. The transmitter reads two unacknowledged frames as an abort.

Top module: `monhs_ctrl`

## Requirements
- R1: After reset, MX and MR are inactive (1), and channel-active, transmit-request, receive-available, abort-seen, overrun and the interrupt are all 0.
- R2: A byte written while the channel is idle appears on the outgoing byte lane at the next frame strobe. At that strobe MX goes active (0) and channel-active goes to 1.
- R3: At a frame strobe where the transmitter is waiting and MR is sampled active (0), MX returns to 1 and transmit-request is set. A later accepted host write clears transmit-request.
- R4: At a frame strobe where MX is sampled 0 and the previous strobe sampled MX as 1, the receiver stores the byte lane, sets receive-available, drives MR to 0 and pulses the interrupt for exactly one clock. A host read clears receive-available.
- R5: While MX stays 0 over further strobes, no new byte is accepted and MR stays 0. A strobe that samples MX as 1 drives MR back to 1.
- R6: When the host writes the next byte as soon as transmit-request rises, a new byte is sent every three frames with no idle frame added.
- R7: End-of-message issued after an acknowledge, with no byte pending, returns the channel to idle at the next strobe, with MX left at 1. An end-of-message request made while idle is dropped.
- R8: After an abort request, MR is driven 1 for the next two frame strobes, and no byte is accepted during those strobes. Normal reception resumes after the next MX rise.
- R9: When MR is sampled inactive at two consecutive strobes while a byte awaits acknowledgement, the transmitter sets abort-seen, drops MX to 1 and clears channel-active.
- R10: A host write made while a byte is still unacknowledged is ignored: the byte in flight is unchanged and overrun is set.
- R11: A write accepted while the channel is idle clears both overrun and abort-seen.
- R12: MX, MR and the outgoing byte lane change only on clocks that carry the frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb_i | input | 1 | One-cycle frame boundary strobe |
| host_wr_i | input | 1 | Write the transmit byte |
| host_wdata_i | input | DATA_W | Transmit byte from the host |
| host_eom_i | input | 1 | End-of-message request pulse |
| host_abort_i | input | 1 | Receiver abort request pulse |
| host_rd_i | input | 1 | Host has read the receive byte |
| bus_mx_n_o | output | 1 | Outgoing MX, active low |
| bus_byte_o | output | DATA_W | Outgoing monitor byte lane |
| bus_mr_n_i | input | 1 | Incoming MR from far receiver, active low |
| bus_mx_n_i | input | 1 | Incoming MX from far transmitter, active low |
| bus_byte_i | input | DATA_W | Incoming monitor byte lane |
| bus_mr_n_o | output | 1 | Outgoing MR, active low |
| rx_data_o | output | DATA_W | Last received byte |
| chan_active_o | output | 1 | Transmit channel is busy with a message |
| tx_req_o | output | 1 | Next transmit byte may be written |
| rx_avail_o | output | 1 | Received byte waiting for the host |
| abort_seen_o | output | 1 | Transmitter saw an abort |
| overrun_o | output | 1 | A write was dropped |
| irq_o | output | 1 | One-cycle pulse per received byte |

## Verification
Every bus-side result is due on the clock that carries the frame strobe. The bench raises the strobe for one clock and samples at the falling edge that follows, so each frame-level effect is checked exactly one strobe after its cause. In loopback, the sent byte shows at the first strobe, its reception at the second and the acknowledge at the third. Each of the 256 byte values is checked at those three points. Host writes, reads and requests take effect on the next rising edge and are checked at the falling edge after it. The interrupt is checked at the single falling edge where its pulse is high.

// File: rtl/monhs_pkg.sv
package monhs_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_WAIT_ACK,
    TX_GAP
  } tx_state_e;
endpackage

// File: rtl/monhs_tx.sv
module monhs_tx #(
  parameter int DATA_W       = 8,
  parameter int ABORT_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eom_req_i,
  input  logic              mr_n_i,
  output logic              mx_n_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              active_o,
  output logic              tx_req_o,
  output logic              abort_seen_o,
  output logic              overrun_o
);
  import monhs_pkg::*;

  localparam int CNT_W = $clog2(ABORT_FRAMES + 1);
  localparam logic [CNT_W-1:0] MISS_LAST = CNT_W'(ABORT_FRAMES - 1);

  tx_state_e         state;
  logic [DATA_W-1:0] data_q;
  logic              pend;
  logic              eom_pend;
  logic [CNT_W-1:0]  miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= TX_IDLE;
      data_q       <= '0;
      pend         <= 1'b0;
      eom_pend     <= 1'b0;
      miss         <= '0;
      mx_n_o       <= 1'b1;
      byte_o       <= '0;
      active_o     <= 1'b0;
      tx_req_o     <= 1'b0;
      abort_seen_o <= 1'b0;
      overrun_o    <= 1'b0;
    end else begin
      // host side
      if (eom_req_i && state != TX_IDLE) eom_pend <= 1'b1;
      if (wr_i) begin
        if (pend) begin
          overrun_o <= 1'b1;
        end else begin
          data_q   <= wr_data_i;
          pend     <= 1'b1;
          tx_req_o <= 1'b0;
          if (state == TX_IDLE) begin
            overrun_o    <= 1'b0;
            abort_seen_o <= 1'b0;
          end
        end
      end
      // bus side, once per frame
      if (frame_stb_i) begin
        unique case (state)
          TX_IDLE: begin
            if (pend) begin
              byte_o   <= data_q;
              mx_n_o   <= 1'b0;
              active_o <= 1'b1;
              miss     <= '0;
              state    <= TX_WAIT_ACK;
            end
          end
          TX_WAIT_ACK: begin
            if (!mr_n_i) begin
              mx_n_o   <= 1'b1;
              tx_req_o <= 1'b1;
              pend     <= 1'b0;
              state    <= TX_GAP;
            end else if (miss == MISS_LAST) begin
              mx_n_o       <= 1'b1;
              abort_seen_o <= 1'b1;
              active_o     <= 1'b0;
              pend         <= 1'b0;
              eom_pend     <= 1'b0;
              state        <= TX_IDLE;
            end else begin
              miss <= miss + CNT_W'(1);
            end
          end
          TX_GAP: begin
            if (pend) begin
              byte_o <= data_q;
              mx_n_o <= 1'b0;
              miss   <= '0;
              state  <= TX_WAIT_ACK;
            end else if (eom_pend) begin
              active_o <= 1'b0;
              eom_pend <= 1'b0;
              state    <= TX_IDLE;
            end
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  p_send_r2: assert property (@(posedge clk) disable iff (rst)
    frame_stb_i && state == TX_IDLE && pend |=> !mx_n_o && active_o);

  p_ack_releases_mx_r3: assert property (@(posedge clk) disable iff (rst)
    frame_stb_i && state == TX_WAIT_ACK && !mr_n_i |=> mx_n_o && tx_req_o);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_seen_o) |-> !active_o && mx_n_o);

  p_overrun_flag_r10: assert property (@(posedge clk) disable iff (rst)
    wr_i && pend |=> overrun_o);

  p_bus_on_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    !frame_stb_i |=> $stable(mx_n_o) && $stable(byte_o));
endmodule

// File: rtl/monhs_rx.sv
module monhs_rx #(
  parameter int DATA_W       = 8,
  parameter int ABORT_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb_i,
  input  logic              mx_n_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              abort_req_i,
  input  logic              rd_i,
  output logic              mr_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              avail_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(ABORT_FRAMES + 1);
  localparam logic [CNT_W-1:0] HOLD_MORE = CNT_W'(ABORT_FRAMES - 1);

  logic             prev_mx_n;
  logic             abort_pend;
  logic [CNT_W-1:0] hold_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mx_n  <= 1'b0;
      abort_pend <= 1'b0;
      hold_left  <= '0;
      mr_n_o     <= 1'b1;
      data_o     <= '0;
      avail_o    <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (abort_req_i) abort_pend <= 1'b1;
      if (rd_i) avail_o <= 1'b0;
      if (frame_stb_i) begin
        prev_mx_n <= mx_n_i;
        if (abort_pend) begin
          mr_n_o     <= 1'b1;
          hold_left  <= HOLD_MORE;
          abort_pend <= 1'b0;
        end else if (hold_left != '0) begin
          mr_n_o    <= 1'b1;
          hold_left <= hold_left - CNT_W'(1);
        end else if (mx_n_i) begin
          mr_n_o <= 1'b1;
        end else if (prev_mx_n) begin
          data_o  <= byte_i;
          avail_o <= 1'b1;
          irq_o   <= 1'b1;
          mr_n_o  <= 1'b0;
        end
      end
    end
  end

  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    frame_stb_i && !mx_n_i && prev_mx_n && !abort_pend && hold_left == '0
    |=> !mr_n_o && avail_o && irq_o);

  p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    frame_stb_i && mx_n_i |=> mr_n_o);

  p_abort_hold_r8: assert property (@(posedge clk) disable iff (rst)
    frame_stb_i && abort_pend |=> mr_n_o && !irq_o);

  p_mr_on_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    !frame_stb_i |=> $stable(mr_n_o));
endmodule

// File: rtl/monhs_ctrl.sv
module monhs_ctrl #(
  parameter int DATA_W       = 8,
  parameter int ABORT_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_eom_i,
  input  logic              host_abort_i,
  input  logic              host_rd_i,
  output logic              bus_mx_n_o,
  output logic [DATA_W-1:0] bus_byte_o,
  input  logic              bus_mr_n_i,
  input  logic              bus_mx_n_i,
  input  logic [DATA_W-1:0] bus_byte_i,
  output logic              bus_mr_n_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              chan_active_o,
  output logic              tx_req_o,
  output logic              rx_avail_o,
  output logic              abort_seen_o,
  output logic              overrun_o,
  output logic              irq_o
);
  monhs_tx #(.DATA_W(DATA_W), .ABORT_FRAMES(ABORT_FRAMES)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .frame_stb_i  (frame_stb_i),
    .wr_i         (host_wr_i),
    .wr_data_i    (host_wdata_i),
    .eom_req_i    (host_eom_i),
    .mr_n_i       (bus_mr_n_i),
    .mx_n_o       (bus_mx_n_o),
    .byte_o       (bus_byte_o),
    .active_o     (chan_active_o),
    .tx_req_o     (tx_req_o),
    .abort_seen_o (abort_seen_o),
    .overrun_o    (overrun_o)
  );

  monhs_rx #(.DATA_W(DATA_W), .ABORT_FRAMES(ABORT_FRAMES)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .frame_stb_i (frame_stb_i),
    .mx_n_i      (bus_mx_n_i),
    .byte_i      (bus_byte_i),
    .abort_req_i (host_abort_i),
    .rd_i        (host_rd_i),
    .mr_n_o      (bus_mr_n_o),
    .data_o      (rx_data_o),
    .avail_o     (rx_avail_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/test_monhs_ctrl.sv
module test_monhs_ctrl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic eom = 1'b0, abrt = 1'b0, rd = 1'b0;
  logic loop = 1'b1;
  logic fe_mx_n = 1'b1, fe_mr_n = 1'b1;
  logic [DW-1:0] fe_byte = '0;

  logic mx_n_o, mr_n_o, active, txreq, avail, aborted, ovr, irq;
  logic [DW-1:0] byte_o, rxdata;
  logic mx_n_in, mr_n_in;
  logic [DW-1:0] byte_in;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign mx_n_in = loop ? mx_n_o : fe_mx_n;
  assign mr_n_in = loop ? mr_n_o : fe_mr_n;
  assign byte_in = loop ? byte_o : fe_byte;

  monhs_ctrl #(.DATA_W(DW), .ABORT_FRAMES(2)) i_monhs_ctrl (
    .clk(clk), .rst(rst), .frame_stb_i(frame_stb),
    .host_wr_i(wr), .host_wdata_i(wdata), .host_eom_i(eom),
    .host_abort_i(abrt), .host_rd_i(rd),
    .bus_mx_n_o(mx_n_o), .bus_byte_o(byte_o), .bus_mr_n_i(mr_n_in),
    .bus_mx_n_i(mx_n_in), .bus_byte_i(byte_in), .bus_mr_n_o(mr_n_o),
    .rx_data_o(rxdata), .chan_active_o(active), .tx_req_o(txreq),
    .rx_avail_o(avail), .abort_seen_o(aborted), .overrun_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame();
    frame_stb = 1'b1; @(negedge clk); frame_stb = 1'b0;
  endtask
  task automatic host_wr(input logic [DW-1:0] v);
    wr = 1'b1; wdata = v; @(negedge clk); wr = 1'b0;
  endtask
  task automatic do_eom();   eom = 1'b1;  @(negedge clk); eom = 1'b0;  endtask
  task automatic do_abort(); abrt = 1'b1; @(negedge clk); abrt = 1'b0; endtask
  task automatic do_rd();    rd = 1'b1;   @(negedge clk); rd = 1'b0;   endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mx", 32'(mx_n_o), 1);
    chk("R1 mr", 32'(mr_n_o), 1);
    chk("R1 flags", 32'({active, txreq, avail, aborted, ovr, irq}), 0);
    frame(); frame();

    // R2 R3 R4 R6: all byte values back to back in loopback
    for (int v = 0; v < 256; v++) begin
      host_wr(DW'(v));
      if (v > 0) chk("R3 tx_req cleared by write", 32'(txreq), 0);
      frame();
      chk("R2 R6 mx active on next frame", 32'(mx_n_o), 0);
      chk("R2 byte lane", 32'(byte_o), 32'(v));
      chk("R2 active", 32'(active), 1);
      frame();
      chk("R4 rx data", 32'(rxdata), 32'(v));
      chk("R4 avail/irq/mr", 32'({avail, irq, mr_n_o}), 32'b110);
      @(negedge clk);
      chk("R4 irq single pulse", 32'(irq), 0);
      do_rd();
      chk("R4 read clears avail", 32'(avail), 0);
      frame();
      chk("R3 ack releases mx", 32'(mx_n_o), 1);
      chk("R3 tx_req set", 32'(txreq), 1);
    end
    do_eom();
    frame();
    chk("R7 eom goes idle", 32'(active), 0);
    chk("R7 mx stays inactive", 32'(mx_n_o), 1);
    chk("R5 mr released", 32'(mr_n_o), 1);

    // R7 eom while idle is dropped
    do_eom();
    host_wr(8'h22);
    frame(); frame(); frame(); frame();
    chk("R7 idle eom dropped", 32'(active), 1);
    do_rd(); do_eom(); frame();
    chk("R7 eom after ack", 32'(active), 0);

    // R10 R11 R12 overrun
    host_wr(8'hA5);
    frame();
    host_wr(8'h3C);
    chk("R10 overrun set", 32'(ovr), 1);
    chk("R12 byte lane holds", 32'(byte_o), 32'hA5);
    chk("R12 mx holds", 32'(mx_n_o), 0);
    frame();
    chk("R10 in-flight byte kept", 32'(rxdata), 32'hA5);
    frame();
    chk("R10 ack", 32'(txreq), 1);
    do_rd(); do_eom(); frame();
    chk("R10 dropped byte not sent", 32'(active), 0);
    host_wr(8'h11);
    chk("R11 overrun cleared", 32'(ovr), 0);
    frame(); frame();
    chk("R10 next byte", 32'(rxdata), 32'h11);
    frame(); do_rd(); do_eom(); frame();

    // R8 R9 abort
    host_wr(8'h5A);
    frame();
    do_abort();
    frame();
    chk("R8 mr inactive frame 1", 32'(mr_n_o), 1);
    chk("R8 byte refused", 32'(avail), 0);
    chk("R9 not yet aborted", 32'(active), 1);
    frame();
    chk("R8 mr inactive frame 2", 32'(mr_n_o), 1);
    chk("R9 abort seen", 32'(aborted), 1);
    chk("R9 idle after abort", 32'({active, mx_n_o}), 32'b01);
    frame();
    chk("R8 still nothing received", 32'(avail), 0);
    host_wr(8'h6B);
    chk("R11 abort cleared", 32'(aborted), 0);
    frame(); frame();
    chk("R8 reception resumes", 32'({avail, rxdata}), 32'h16B);
    frame(); do_rd(); do_eom(); frame();

    // R4 R5 receiver driven directly
    loop = 1'b0;
    fe_mx_n = 1'b1; frame();
    fe_mx_n = 1'b0; fe_byte = 8'h77; frame();
    chk("R4 direct accept", 32'({avail, mr_n_o, rxdata}), 32'h277);
    do_rd();
    fe_byte = 8'h88; frame();
    chk("R5 no second accept", 32'({avail, irq, mr_n_o}), 0);
    chk("R5 data kept", 32'(rxdata), 32'h77);
    fe_mx_n = 1'b1; frame();
    chk("R5 mr released", 32'(mr_n_o), 1);
    fe_mx_n = 1'b0; fe_byte = 8'h99; frame();
    chk("R5 new byte after rise", 32'({avail, rxdata}), 32'h199);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule